// File: doc/BRIEF.md
# Synchronous Memory Clock Generator

This block produces the clock that a multi-bank static memory controller drives to synchronous external devices. Each bank supplies a synchronous-mode flag, a continuous-clock enable, and two divide values: one for reads and one for writes. The controller's sequencing logic reports when a transaction is in progress, which bank it targets, and whether it writes. The block then outputs a divided memory clock and a flag that is high while that clock is running.

There are two operating modes. In gated mode, the clock runs only while a transaction is in flight to a bank that is set up as synchronous. The ratio comes from the divide value of that bank for the current direction. In continuous mode, the clock never stops. This mode is enabled only through the first bank, and only when that bank is itself synchronous. In continuous mode, the first bank's read divide value sets the ratio for every bank.

The clock always starts with a full high phase and stops only after a full low phase. A changed ratio is picked up only at the start of a new period. As a result, the memory never sees a shortened pulse.

Top module: `mem_clk_gen`

## Requirements
- R1: In gated mode, the memory clock toggles only while `xact_active_i` is high and the selected bank's `sync_mode_i` bit is set. In every other case the clock is held low and `clk_active_o` is low. Bank k is selected by `xact_bank_i` = k-1.
- R2: A divide value N gives a period of N+1 system clocks. The high phase lasts floor((N+1)/2) clocks and the low phase lasts for the rest of the period. In gated mode, N is taken from the selected bank's write field when `xact_write_i` is 1 and from its read field otherwise. Bank k's fields sit at bits [(k-1)*DIV_W +: DIV_W] of `rd_div_i` and `wr_div_i`.
- R3: In continuous mode, the clock runs without a break. This holds with no transaction, during asynchronous transactions and during synchronous transactions, and `clk_active_o` stays high throughout.
- R4: Only bit 0 of `cont_en_i` (bank 1) can turn on continuous mode. Bits 1 to 3 have no effect.
- R5: Continuous mode is in force only when both `cont_en_i[0]` and `sync_mode_i[0]` are set.
- R6: In continuous mode, the ratio comes from bank 1's read field. Bank 1's write field is ignored, even for write transactions.
- R7: In continuous mode, the divide fields of banks 2 to 4 have no effect on the clock.
- R8: A divide value of 0 behaves as 1, giving a period of 2 clocks with 1 high and 1 low.
- R9: The clock starts with a full high phase and stops only after a complete low phase. A divide value that changes while the clock runs is applied from the next period onward.
- R10: After reset, `mem_clk_o` is low and `clk_active_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cont_en_i | input | NUM_BANKS | Per-bank continuous-clock enable (only bit 0 acts) |
| sync_mode_i | input | NUM_BANKS | Per-bank synchronous-mode flag |
| rd_div_i | input | NUM_BANKS*DIV_W | Per-bank read divide values |
| wr_div_i | input | NUM_BANKS*DIV_W | Per-bank write divide values |
| xact_active_i | input | 1 | A transaction is in progress |
| xact_bank_i | input | BANK_W | Bank of the current transaction (0 = bank 1) |
| xact_write_i | input | 1 | Current transaction is a write |
| mem_clk_o | output | 1 | Divided memory clock |
| clk_active_o | output | 1 | Memory clock is running |

## Verification
The hardest case to reach from the ports is a ratio change while the clock is running. The new value must wait for a period boundary, and the period already under way must keep its length. The stimulus reaches this in continuous mode: it rewrites bank 1's read field at an arbitrary cycle, lets any partial period finish, and then compares whole measured periods against the new ratio. A second difficult case is a transaction to another bank, with a different write ratio, arriving while continuous mode is on. The stimulus drives exactly that transaction and requires every period to keep bank 1's read ratio.

// File: rtl/mclk_pkg.sv
package mclk_pkg;
  // Effective divide: zero is promoted to one (minimum divide-by-2).
  function automatic int unsigned eff_div(input int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction

  // High-phase length in system clocks for an effective divide n.
  function automatic int unsigned high_len(input int unsigned n);
    return (n + 1) / 2;
  endfunction

  typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} ph_state_t;
endpackage

// File: rtl/mclk_div_select.sv
module mclk_div_select #(
  parameter int NUM_BANKS = 4,
  parameter int DIV_W     = 4,
  parameter int BANK_W    = 2
) (
  input  logic [NUM_BANKS-1:0]       cont_en_i,
  input  logic [NUM_BANKS-1:0]       sync_mode_i,
  input  logic [NUM_BANKS*DIV_W-1:0] rd_div_i,
  input  logic [NUM_BANKS*DIV_W-1:0] wr_div_i,
  input  logic                       xact_active_i,
  input  logic [BANK_W-1:0]          xact_bank_i,
  input  logic                       xact_write_i,
  output logic                       run_req_o,
  output logic [DIV_W-1:0]           div_o
);
  import mclk_pkg::*;

  logic [DIV_W-1:0] rd_arr [NUM_BANKS];
  logic [DIV_W-1:0] wr_arr [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_unpack
    assign rd_arr[b] = rd_div_i[b*DIV_W +: DIV_W];
    assign wr_arr[b] = wr_div_i[b*DIV_W +: DIV_W];
  end

  // Continuous enables of banks other than the first carry no function.
  if (NUM_BANKS > 1) begin : g_upper
    logic unused_cont_hi;
    assign unused_cont_hi = ^cont_en_i[NUM_BANKS-1:1];
  end

  logic             cont_mode;
  logic             sel_sync;
  logic [DIV_W-1:0] sel_rd, sel_wr, raw_div;

  always_comb begin
    sel_sync = 1'b0;
    sel_rd   = '0;
    sel_wr   = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (xact_bank_i == BANK_W'(b)) begin
        sel_sync = sync_mode_i[b];
        sel_rd   = rd_arr[b];
        sel_wr   = wr_arr[b];
      end
    end
  end

  assign cont_mode = cont_en_i[0] & sync_mode_i[0];
  assign run_req_o = cont_mode | (xact_active_i & sel_sync);
  assign raw_div   = cont_mode ? rd_arr[0] : (xact_write_i ? sel_wr : sel_rd);
  assign div_o     = DIV_W'(eff_div(32'(raw_div)));
endmodule

// File: rtl/mclk_phase_gen.sv
module mclk_phase_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_req_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mem_clk_o,
  output logic             active_o,
  output logic             period_end_o,
  output logic [DIV_W-1:0] cur_div_o
);
  import mclk_pkg::*;

  ph_state_t        state;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cur_div;
  logic             mclk_q;
  logic [DIV_W:0]   hi_len;
  logic [DIV_W:0]   cnt_next;

  always_comb begin
    hi_len   = (DIV_W+1)'(high_len(32'(cur_div)));
    cnt_next = {1'b0, cnt} + 1'b1;
  end

  assign period_end_o = (state == PH_RUN) && (cnt == cur_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= PH_IDLE;
      cnt     <= '0;
      cur_div <= DIV_W'(1);
      mclk_q  <= 1'b0;
    end else if (state == PH_IDLE || period_end_o) begin
      cnt <= '0;
      if (run_req_i) begin
        state   <= PH_RUN;
        cur_div <= div_i;
        mclk_q  <= 1'b1;
      end else begin
        state   <= PH_IDLE;
        mclk_q  <= 1'b0;
      end
    end else begin
      cnt    <= cnt_next[DIV_W-1:0];
      mclk_q <= (cnt_next < hi_len);
    end
  end

  assign mem_clk_o = mclk_q;
  assign active_o  = (state == PH_RUN);
  assign cur_div_o = cur_div;
endmodule

// File: rtl/mem_clk_gen.sv
module mem_clk_gen #(
  parameter int NUM_BANKS = 4,
  parameter int DIV_W     = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_BANKS-1:0]       cont_en_i,
  input  logic [NUM_BANKS-1:0]       sync_mode_i,
  input  logic [NUM_BANKS*DIV_W-1:0] rd_div_i,
  input  logic [NUM_BANKS*DIV_W-1:0] wr_div_i,
  input  logic                       xact_active_i,
  input  logic [BANK_W-1:0]          xact_bank_i,
  input  logic                       xact_write_i,
  output logic                       mem_clk_o,
  output logic                       clk_active_o
);
  // Named internal events, observed by the bound checker.
  logic             run_req;
  logic [DIV_W-1:0] sel_div;
  logic             period_end;
  logic [DIV_W-1:0] cur_div;

  mclk_div_select #(
    .NUM_BANKS(NUM_BANKS), .DIV_W(DIV_W), .BANK_W(BANK_W)
  ) u_sel (
    .cont_en_i    (cont_en_i),
    .sync_mode_i  (sync_mode_i),
    .rd_div_i     (rd_div_i),
    .wr_div_i     (wr_div_i),
    .xact_active_i(xact_active_i),
    .xact_bank_i  (xact_bank_i),
    .xact_write_i (xact_write_i),
    .run_req_o    (run_req),
    .div_o        (sel_div)
  );

  mclk_phase_gen #(.DIV_W(DIV_W)) u_ph (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_req_i   (run_req),
    .div_i       (sel_div),
    .mem_clk_o   (mem_clk_o),
    .active_o    (clk_active_o),
    .period_end_o(period_end),
    .cur_div_o   (cur_div)
  );
endmodule

// File: rtl/mem_clk_gen_chk.sv
module mem_clk_gen_chk #(
  parameter int NUM_BANKS = 4,
  parameter int DIV_W     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_BANKS-1:0] cont_en_i,
  input logic [NUM_BANKS-1:0] sync_mode_i,
  input logic                 mem_clk_o,
  input logic                 clk_active_o,
  input logic                 run_req,
  input logic                 period_end,
  input logic [DIV_W-1:0]     cur_div
);
  logic cont_req;
  assign cont_req = cont_en_i[0] && sync_mode_i[0];

  p_gated_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_req && !clk_active_o) |=> (!clk_active_o && !mem_clk_o));

  p_cont_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_req && clk_active_o) |=> clk_active_o);

  p_min_div_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_active_o |-> (cur_div != '0));

  p_start_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_active_o) |-> mem_clk_o);

  p_stop_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_active_o) |-> (!mem_clk_o && !$past(mem_clk_o)));

  p_div_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_active_o && !period_end) |=> $stable(cur_div));

  p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_active_o |-> !mem_clk_o);
endmodule

bind mem_clk_gen mem_clk_gen_chk #(.NUM_BANKS(NUM_BANKS), .DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cont_en_i   (cont_en_i),
  .sync_mode_i (sync_mode_i),
  .mem_clk_o   (mem_clk_o),
  .clk_active_o(clk_active_o),
  .run_req     (run_req),
  .period_end  (period_end),
  .cur_div     (cur_div)
);

// File: tb/sim_mem_clk_gen.sv
module sim_mem_clk_gen;
  localparam int NB = 4;
  localparam int DW = 4;
  localparam int BW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NB-1:0]    cont_en = '0;
  logic [NB-1:0]    sync_m = '0;
  logic [NB*DW-1:0] rd_div = '0;
  logic [NB*DW-1:0] wr_div = '0;
  logic             x_act = 1'b0;
  logic [BW-1:0]    x_bank = '0;
  logic             x_wr = 1'b0;
  logic             mclk, mact;

  mem_clk_gen #(.NUM_BANKS(NB), .DIV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cont_en_i(cont_en), .sync_mode_i(sync_m),
    .rd_div_i(rd_div), .wr_div_i(wr_div), .xact_active_i(x_act),
    .xact_bank_i(x_bank), .xact_write_i(x_wr),
    .mem_clk_o(mclk), .clk_active_o(mact)
  );

  typedef struct { int hi; int lo; string req; } per_t;
  per_t exp_q[$];
  per_t cur_e;
  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Driver side: expected period shape from the divide rule.
  task automatic push_periods(input int n, input int count, input string req);
    int p;
    per_t e;
    p = ((n < 1) ? 1 : n) + 1;
    e.hi = p / 2;
    e.lo = p - e.hi;
    e.req = req;
    for (int i = 0; i < count; i++) exp_q.push_back(e);
  endtask

  task automatic wait_drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic set_div(input int bank, input int rd, input int wr);
    rd_div[bank*DW +: DW] = DW'(rd);
    wr_div[bank*DW +: DW] = DW'(wr);
  endtask

  task automatic count_rises(input int n, output int rises, output int inact);
    logic prev;
    rises = 0;
    inact = 0;
    prev = mclk;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mclk && !prev) rises++;
      if (!mact) inact++;
      prev = mclk;
    end
  endtask

  // Monitor: measures each full period (rise to rise) and compares.
  logic mon_prev = 1'b0;
  bit   armed = 1'b0;
  int   hi_c = 0;
  int   lo_c = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mclk && !mon_prev) begin
        if (armed && exp_q.size() > 0) begin
          cur_e = exp_q.pop_front();
          check(hi_c == cur_e.hi, cur_e.req, "high phase", hi_c, cur_e.hi);
          check(lo_c == cur_e.lo, cur_e.req, "low phase", lo_c, cur_e.lo);
        end
        armed = (exp_q.size() > 0);
        hi_c = 1;
        lo_c = 0;
      end else if (mclk) hi_c++;
      else lo_c++;
      mon_prev = mclk;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    int r, ia;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(mclk == 1'b0, "R10", "clock after reset", int'(mclk), 0);
    check(mact == 1'b0, "R10", "active after reset", int'(mact), 0);
    rst_n = 1'b1;

    // R1: nothing configured, no transaction
    count_rises(60, r, ia);
    check(r == 0, "R1", "rises when idle", r, 0);

    // R1: asynchronous bank transaction gives no clock
    x_bank = 2'd1; x_act = 1'b1;
    count_rises(60, r, ia);
    check(r == 0, "R1", "rises on async bank", r, 0);
    x_act = 1'b0;
    repeat (4) @(negedge clk);

    // R2: synchronous read on bank 3, N=4
    sync_m[2] = 1'b1;
    set_div(2, 4, 2);
    push_periods(4, 3, "R2");
    x_bank = 2'd2; x_wr = 1'b0; x_act = 1'b1;
    wait_drain();
    x_act = 1'b0;
    repeat (12) @(negedge clk);
    check(mclk == 1'b0, "R9", "clock after stop", int'(mclk), 0);
    check(mact == 1'b0, "R9", "active after stop", int'(mact), 0);

    // R2: synchronous write on bank 3 uses write field N=2
    push_periods(2, 3, "R2");
    x_wr = 1'b1; x_act = 1'b1;
    wait_drain();
    x_act = 1'b0;
    repeat (12) @(negedge clk);

    // R8: divide 0 behaves as 1
    sync_m[1] = 1'b1;
    set_div(1, 0, 7);
    push_periods(0, 4, "R8");
    x_bank = 2'd1; x_wr = 1'b0; x_act = 1'b1;
    wait_drain();
    x_act = 1'b0;
    repeat (12) @(negedge clk);

    // R4: continuous enable on bank 2 only has no effect
    cont_en[1] = 1'b1;
    count_rises(60, r, ia);
    check(r == 0, "R4", "rises with bank 2 continuous bit", r, 0);

    // R5: bank 1 continuous bit without synchronous mode
    cont_en[0] = 1'b1;
    count_rises(60, r, ia);
    check(r == 0, "R5", "rises with bank 1 async", r, 0);

    // R3: continuous mode with no transaction, N=5
    set_div(0, 5, 2);
    sync_m[0] = 1'b1;
    repeat (20) @(negedge clk);
    push_periods(5, 3, "R3");
    wait_drain();

    // R6: write to bank 1 still uses bank 1 read field
    x_bank = 2'd0; x_wr = 1'b1; x_act = 1'b1;
    repeat (20) @(negedge clk);
    push_periods(5, 3, "R6");
    wait_drain();

    // R7: write to bank 4 with its own fields still uses bank 1 read field
    sync_m[3] = 1'b1;
    set_div(3, 2, 1);
    x_bank = 2'd3;
    repeat (20) @(negedge clk);
    push_periods(5, 3, "R7");
    wait_drain();

    // R3: clock never idles across async transaction and gaps
    x_bank = 2'd1; sync_m[1] = 1'b0;
    count_rises(40, r, ia);
    check(ia == 0, "R3", "inactive cycles in continuous mode", ia, 0);
    check(r == 6, "R3", "rises in 40 cycles at N=5", r, 6);
    x_act = 1'b0;

    // R9: ratio change while running takes effect at a boundary
    set_div(0, 2, 2);
    repeat (20) @(negedge clk);
    push_periods(2, 3, "R9");
    wait_drain();
    cont_en[0] = 1'b0;
    repeat (12) @(negedge clk);
    check(mclk == 1'b0, "R9", "clock after continuous off", int'(mclk), 0);
    check(mact == 1'b0, "R9", "active after continuous off", int'(mact), 0);

    finish_up();
  end
endmodule